// File: doc/BRIEF.md
# Sequenced Clear-on-Read Packet Statistics

This block keeps packet statistics for a physical-layer device: a 32-bit count of completed packets and a 16-bit count of errored packets for each direction, plus a 6-bit count of link losses. A host reaches the counters through a 16-bit register read port. Requests and responses each use a valid/ready handshake. Each direction's counters form a group of three registers: low packet word, high packet word, and error word.

Reading a group's low word freezes that group, so the host sees one consistent snapshot of the 32-bit count. The snapshot is cleared only when the host reads the group's three registers in strict order (low, high, error). If the host repeats a read, skips a register or reads any other address during the freeze, the freeze ends and nothing is cleared. Packets that arrive during a freeze are held in a shadow store and are never lost. After a clear, counting restarts from the shadow contents. After an aborted sequence, the shadow contents are added to the frozen value. The link-loss count is cleared each time its register is read.

Top module: `pkt_stat_unit`

## Requirements
- R1: After reset every counter reads zero, no response is pending and `rd_req_ready` is high.
- R2: Register map. Address 0 holds the TX packet count bits [15:0], address 1 holds bits [31:16], and address 2 holds the TX error count. Addresses 4, 5 and 6 hold the same three registers for RX. Each `*_pkt_done` pulse adds one packet and each `*_pkt_err` pulse adds one error.
- R3: No counter wraps. The packet, error and link-loss counts stop at their all-ones value.
- R4: A read of a group's low word freezes that group. Later reads of the group during the freeze return the snapshot value, even if packets keep arriving.
- R5: Events that arrive during a freeze, including the cycle in which the freeze starts, are kept. None is lost.
- R6: A read of the low, high and error registers in that exact order clears the group. The error read returns the frozen value, and the counters then equal the events held during the freeze.
- R7: During a freeze, an out-of-order read, a repeated read or a read of any other address ends the freeze without clearing. The events held during the freeze are added to the frozen value.
- R8: Address 3 returns the link-loss count in bits [15:10] with all other bits zero. Each `link_lost` pulse adds one to the count. A read of address 3 clears the count, but a pulse in the same cycle as that read counts as one.
- R9: Addresses 7 to 15 read as zero and do not disturb any counter.
- R10: A request is accepted when `rd_req_valid` and `rd_req_ready` are both high. `rd_req_ready` is high when no response is held or when `rd_rsp_ready` is high. Responses appear one cycle after acceptance. While `rd_rsp_ready` is low, a pending response holds its valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pkt_done | input | 1 | One TX packet completed |
| tx_pkt_err | input | 1 | One TX packet errored |
| rx_pkt_done | input | 1 | One RX packet completed |
| rx_pkt_err | input | 1 | One RX packet errored |
| link_lost | input | 1 | One link loss event |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_req_addr | input | 4 | Register address |
| rd_rsp_valid | output | 1 | Read data present |
| rd_rsp_ready | input | 1 | Host takes read data |
| rd_rsp_data | output | 16 | Read data |

## Verification
The bench drives several read patterns. A clean ordered sequence shows that the group clears. A repeated high-word read and a detour to an unmapped address each show that the freeze ends with the held events added and nothing cleared. Packets injected inside a freeze show that the snapshot stays fixed while the shadow store fills. A long burst that pushes the packet count past 16 bits and saturates the error and link counters shows that the 32-bit count splits correctly across two words and that no counter wraps. A stalled response with new events arriving shows that back-pressure holds the response data and blocks new requests.

// File: rtl/pkt_stat_pkg.sv
`timescale 1ns/1ps
package pkt_stat_pkg;
  localparam int REG_W      = 16;
  localparam int GROUP_REGS = 3;

  typedef enum logic [1:0] {
    SLOT_LOW  = 2'd0,
    SLOT_HIGH = 2'd1,
    SLOT_ERR  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;
endpackage

// File: rtl/link_loss_cnt.sv
`timescale 1ns/1ps
module link_loss_cnt #(
  parameter int LINK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              clr,
  output logic [LINK_W-1:0] count
);
  localparam logic [LINK_W-1:0] LMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (clr)        count <= LINK_W'(evt);
    else if (evt && count != LMAX) count <= count + 1'b1;
  end

  // R8: a full counter stays full unless read
  a_r8_link_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (count == LMAX && !clr) |=> count == LMAX);
endmodule

// File: rtl/pkt_stat_group.sv
`timescale 1ns/1ps
module pkt_stat_group
  import pkt_stat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BASE   = 0,
  parameter int PKT_W  = 32,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_evt,
  input  logic              err_evt,
  input  logic              acc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output logic [REG_W-1:0]  word
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [PKT_W-1:0]  PMAX   = '1;
  localparam logic [ERR_W-1:0]  EMAX   = '1;

  logic [ADDR_W-1:0] off;
  slot_e             slot;
  logic              frozen_q;
  logic [1:0]        step_q;
  logic [PKT_W-1:0]  live_pkt, sh_pkt, sh_pkt_nx, inc_pkt, fold_pkt;
  logic [ERR_W-1:0]  live_err, sh_err, sh_err_nx, inc_err, fold_err;
  logic [PKT_W:0]    sum_sp, sum_lp, sum_fp;
  logic [ERR_W:0]    sum_se, sum_le, sum_fe;
  logic              frz_start, in_seq, clr, abort;

  assign off  = acc_addr - BASE_A;
  assign hit  = off < ADDR_W'(GROUP_REGS);
  assign slot = hit ? slot_e'(off[1:0]) : SLOT_NONE;

  // saturating sums: shadow + event, live + event, live + shadow
  always_comb begin
    sum_sp    = {1'b0, sh_pkt} + (PKT_W+1)'(pkt_evt);
    sh_pkt_nx = sum_sp[PKT_W] ? PMAX : sum_sp[PKT_W-1:0];
    sum_lp    = {1'b0, live_pkt} + (PKT_W+1)'(pkt_evt);
    inc_pkt   = sum_lp[PKT_W] ? PMAX : sum_lp[PKT_W-1:0];
    sum_fp    = {1'b0, live_pkt} + {1'b0, sh_pkt_nx};
    fold_pkt  = sum_fp[PKT_W] ? PMAX : sum_fp[PKT_W-1:0];
    sum_se    = {1'b0, sh_err} + (ERR_W+1)'(err_evt);
    sh_err_nx = sum_se[ERR_W] ? EMAX : sum_se[ERR_W-1:0];
    sum_le    = {1'b0, live_err} + (ERR_W+1)'(err_evt);
    inc_err   = sum_le[ERR_W] ? EMAX : sum_le[ERR_W-1:0];
    sum_fe    = {1'b0, live_err} + {1'b0, sh_err_nx};
    fold_err  = sum_fe[ERR_W] ? EMAX : sum_fe[ERR_W-1:0];
  end

  assign frz_start = acc && !frozen_q && slot == SLOT_LOW;
  assign in_seq    = acc && frozen_q && hit && off[1:0] == step_q;
  assign clr       = in_seq && step_q == 2'd2;
  assign abort     = acc && frozen_q && !in_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      step_q   <= 2'd0;
      live_pkt <= '0;
      live_err <= '0;
      sh_pkt   <= '0;
      sh_err   <= '0;
    end else if (frozen_q) begin
      if (clr) begin
        live_pkt <= sh_pkt_nx;
        live_err <= sh_err_nx;
        sh_pkt   <= '0;
        sh_err   <= '0;
        frozen_q <= 1'b0;
        step_q   <= 2'd0;
      end else if (abort) begin
        live_pkt <= fold_pkt;
        live_err <= fold_err;
        sh_pkt   <= '0;
        sh_err   <= '0;
        frozen_q <= 1'b0;
        step_q   <= 2'd0;
      end else begin
        sh_pkt <= sh_pkt_nx;
        sh_err <= sh_err_nx;
        if (in_seq) step_q <= step_q + 2'd1;
      end
    end else if (frz_start) begin
      frozen_q <= 1'b1;
      step_q   <= 2'd1;
      sh_pkt   <= sh_pkt_nx;
      sh_err   <= sh_err_nx;
    end else begin
      live_pkt <= inc_pkt;
      live_err <= inc_err;
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_LOW:  word = live_pkt[REG_W-1:0];
      SLOT_HIGH: word = REG_W'(live_pkt[PKT_W-1:REG_W]);
      SLOT_ERR:  word = REG_W'(live_err);
      default:   word = '0;
    endcase
  end

  // R4: snapshot does not move while frozen and untouched
  a_r4_hold_while_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !acc) |=> ($stable(live_pkt) && $stable(live_err)));
  // R3: a full packet count never wraps outside a freeze
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen_q && live_pkt == PMAX) |=> live_pkt == PMAX);
  // R6: sequence position is always the high or error slot while frozen
  a_r6_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (step_q == 2'd1 || step_q == 2'd2));
  // R6: the final ordered read ends the freeze
  a_r6_clear_unfreezes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !frozen_q);
  // R7: an aborted sequence never lowers the count
  a_r7_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (live_pkt >= $past(live_pkt) && live_err >= $past(live_err)));
endmodule

// File: rtl/pkt_stat_unit.sv
`timescale 1ns/1ps
module pkt_stat_unit
  import pkt_stat_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PKT_W     = 32,
  parameter int ERR_W     = 16,
  parameter int LINK_W    = 6,
  parameter int TX_BASE   = 0,
  parameter int RX_BASE   = 4,
  parameter int LINK_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pkt_done,
  input  logic              tx_pkt_err,
  input  logic              rx_pkt_done,
  input  logic              rx_pkt_err,
  input  logic              link_lost,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [REG_W-1:0]  rd_rsp_data
);
  localparam int NGRP     = 2;
  localparam int LINK_LSB = REG_W - LINK_W;

  logic              acc;
  logic [NGRP-1:0]   g_pkt, g_err, g_hit;
  logic [REG_W-1:0]  g_word [NGRP];
  logic              link_hit;
  logic [LINK_W-1:0] link_cnt;
  logic [REG_W-1:0]  rd_mux;

  assign rd_req_ready = !rd_rsp_valid || rd_rsp_ready;
  assign acc          = rd_req_valid && rd_req_ready;
  assign g_pkt        = {rx_pkt_done, tx_pkt_done};
  assign g_err        = {rx_pkt_err, tx_pkt_err};
  assign link_hit     = rd_req_addr == ADDR_W'(LINK_ADDR);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pkt_stat_group #(
      .ADDR_W(ADDR_W),
      .BASE  (g == 0 ? TX_BASE : RX_BASE),
      .PKT_W (PKT_W),
      .ERR_W (ERR_W)
    ) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .pkt_evt (g_pkt[g]),
      .err_evt (g_err[g]),
      .acc     (acc),
      .acc_addr(rd_req_addr),
      .hit     (g_hit[g]),
      .word    (g_word[g])
    );
  end

  link_loss_cnt #(.LINK_W(LINK_W)) u_link (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (link_lost),
    .clr  (acc && link_hit),
    .count(link_cnt)
  );

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++)
      if (g_hit[g]) rd_mux = rd_mux | g_word[g];
    if (link_hit) rd_mux = rd_mux | (REG_W'(link_cnt) << LINK_LSB);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else if (acc) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= rd_mux;
    end else if (rd_rsp_ready) begin
      rd_rsp_valid <= 1'b0;
    end
  end

  // R10: a stalled response keeps valid and data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_data)));
  // R10: nothing new is taken while a response is stalled
  a_r10_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |-> !rd_req_ready);
  // R8: link field lands only in bits above the low ten
  a_r8_link_field: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && link_hit) |=> rd_rsp_data[LINK_LSB-1:0] == '0);
endmodule

// File: tb/pkt_stat_unit_test.sv
`timescale 1ns/1ps
module pkt_stat_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_pkt_done = 0, tx_pkt_err = 0, rx_pkt_done = 0, rx_pkt_err = 0, link_lost = 0;
  logic rd_req_valid = 0, rd_rsp_ready = 1;
  logic [3:0] rd_req_addr = '0;
  logic rd_req_ready, rd_rsp_valid;
  logic [15:0] rd_rsp_data;

  int errors = 0, checks = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  pkt_stat_unit uut (
    .clk(clk), .rst_n(rst_n),
    .tx_pkt_done(tx_pkt_done), .tx_pkt_err(tx_pkt_err),
    .rx_pkt_done(rx_pkt_done), .rx_pkt_err(rx_pkt_err),
    .link_lost(link_lost),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data)
  );

  // behavioural reference model
  localparam longint PMAX = 64'hFFFF_FFFF;
  localparam longint EMAX = 65535;
  localparam int     LMAX = 63;
  longint m_pkt [2], m_err [2], m_spk [2], m_ser [2];
  bit     m_frz [2];
  int     m_step [2];
  int     m_ll;
  bit     m_rv;
  int     m_rd;

  function automatic longint satv(longint v, longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic int mread(int a);
    case (a)
      0: return int'(m_pkt[0] & 64'hFFFF);
      1: return int'(m_pkt[0] >> 16);
      2: return int'(m_err[0]);
      3: return m_ll * 1024;
      4: return int'(m_pkt[1] & 64'hFFFF);
      5: return int'(m_pkt[1] >> 16);
      6: return int'(m_err[1]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_pkt[g] = 0; m_err[g] = 0; m_spk[g] = 0; m_ser[g] = 0;
        m_frz[g] = 0; m_step[g] = 0;
      end
      m_ll = 0; m_rv = 0; m_rd = 0;
    end else begin
      bit acc;
      int a;
      acc = rd_req_valid && (!m_rv || rd_rsp_ready);
      a = int'(rd_req_addr);
      if (acc) begin m_rv = 1; m_rd = mread(a); end
      else if (rd_rsp_ready) m_rv = 0;
      for (int g = 0; g < 2; g++) begin
        int ep, ee, k;
        bit hit;
        ep = (g == 0) ? int'(tx_pkt_done) : int'(rx_pkt_done);
        ee = (g == 0) ? int'(tx_pkt_err)  : int'(rx_pkt_err);
        k = a - 4 * g;
        hit = acc && k >= 0 && k <= 2;
        if (!m_frz[g]) begin
          if (hit && k == 0) begin
            m_frz[g] = 1; m_step[g] = 1;
            m_spk[g] = ep; m_ser[g] = ee;
          end else begin
            m_pkt[g] = satv(m_pkt[g] + ep, PMAX);
            m_err[g] = satv(m_err[g] + ee, EMAX);
          end
        end else begin
          longint sp, se;
          sp = satv(m_spk[g] + ep, PMAX);
          se = satv(m_ser[g] + ee, EMAX);
          if (hit && k == m_step[g]) begin
            if (k == 2) begin
              m_pkt[g] = sp; m_err[g] = se;
              m_spk[g] = 0; m_ser[g] = 0; m_frz[g] = 0;
            end else begin
              m_step[g]++; m_spk[g] = sp; m_ser[g] = se;
            end
          end else if (acc) begin
            m_pkt[g] = satv(m_pkt[g] + sp, PMAX);
            m_err[g] = satv(m_err[g] + se, EMAX);
            m_spk[g] = 0; m_ser[g] = 0; m_frz[g] = 0;
          end else begin
            m_spk[g] = sp; m_ser[g] = se;
          end
        end
      end
      if (acc && a == 3) m_ll = int'(link_lost);
      else if (link_lost) m_ll = (m_ll < LMAX) ? m_ll + 1 : LMAX;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(rd_rsp_valid == m_rv, tag, int'(rd_rsp_valid), int'(m_rv));
      chk(rd_req_ready == (!m_rv || rd_rsp_ready), tag, int'(rd_req_ready), int'(!m_rv || rd_rsp_ready));
      if (m_rv) chk(int'(rd_rsp_data) == m_rd, tag, int'(rd_rsp_data), m_rd);
    end
  end

  task automatic rd_chk(int addr, int exp, string req);
    @(negedge clk);
    rd_req_addr = 4'(addr);
    rd_req_valid = 1;
    @(negedge clk);
    rd_req_valid = 0;
    #1;
    chk(rd_rsp_valid && int'(rd_rsp_data) == exp, req, int'(rd_rsp_data), exp);
  endtask

  task automatic events(int ntd, int nte, int nrd, int nre, int nll);
    int n;
    n = ntd;
    if (nte > n) n = nte;
    if (nrd > n) n = nrd;
    if (nre > n) n = nre;
    if (nll > n) n = nll;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_pkt_done = (i < ntd); tx_pkt_err = (i < nte);
      rx_pkt_done = (i < nrd); rx_pkt_err = (i < nre);
      link_lost   = (i < nll);
    end
    @(negedge clk);
    tx_pkt_done = 0; tx_pkt_err = 0; rx_pkt_done = 0; rx_pkt_err = 0; link_lost = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk(!rd_rsp_valid, "R1", int'(rd_rsp_valid), 0);
    chk(rd_req_ready, "R1", int'(rd_req_ready), 1);
    for (int a = 0; a < 7; a++) rd_chk(a, 0, "R1");

    // R2 map and counting, R6 ordered clear, R8 link field
    tag = "R2";
    events(5, 3, 7, 2, 4);
    rd_chk(0, 5, "R2");
    rd_chk(1, 0, "R2");
    rd_chk(2, 3, "R6");
    rd_chk(3, 4 * 1024, "R8");
    rd_chk(3, 0, "R8");
    rd_chk(4, 7, "R2");
    rd_chk(5, 0, "R2");
    rd_chk(6, 2, "R2");
    rd_chk(0, 0, "R6");

    // R4/R5: events during freeze go to shadow
    tag = "R5";
    events(4, 0, 0, 0, 0);
    rd_chk(1, 0, "R4");
    rd_chk(2, 0, "R4");
    rd_chk(0, 4, "R5");

    // R7: repeated read aborts without clearing
    tag = "R7";
    events(2, 0, 0, 0, 0);
    rd_chk(1, 0, "R7");
    rd_chk(1, 0, "R7");
    rd_chk(2, 0, "R7");
    rd_chk(0, 6, "R7");
    // R9: unmapped address aborts and reads zero
    rd_chk(9, 0, "R9");
    rd_chk(0, 6, "R7");
    rd_chk(1, 0, "R6");
    rd_chk(2, 0, "R6");
    rd_chk(0, 0, "R6");
    rd_chk(1, 0, "R6");
    rd_chk(2, 0, "R6");

    // R3: long burst past 16 bits and into saturation
    tag = "R3";
    events(70000, 70000, 0, 0, 70);
    rd_chk(3, 63 * 1024, "R3");
    rd_chk(0, 4464, "R3");
    rd_chk(1, 1, "R3");
    rd_chk(2, 65535, "R3");

    // R10: back-pressure
    tag = "R10";
    @(negedge clk);
    rd_rsp_ready = 0;
    rd_req_addr = 4'd3;
    rd_req_valid = 1;
    @(negedge clk);
    link_lost = 1;
    repeat (3) @(negedge clk);
    link_lost = 0;
    #1;
    chk(rd_rsp_valid && rd_rsp_data == 16'd0, "R10", int'(rd_rsp_data), 0);
    chk(!rd_req_ready, "R10", int'(rd_req_ready), 0);
    @(negedge clk);
    rd_req_valid = 0;
    rd_rsp_ready = 1;
    repeat (2) @(negedge clk);
    rd_chk(3, 3 * 1024, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule